// File: doc/BRIEF.md
# Reset Supervisor with Cold-Start Flag

This block merges three reset sources into a single active-high processor reset: a raw supply-low comparator level, a reset request from the debug port, and a reset request from the watchdog. The comparator level is first brought into the clock domain. It is then filtered, so a supply-low condition counts only after it has been seen for a set number of consecutive cycles. Whatever triggers a reset, the output is held for a fixed number of extra cycles after the last active source goes away.

Two mode inputs tell the block that the processor is idle or powered down. The supply-low and debug sources stay active in every mode. The watchdog request is ignored in both low-power modes. A cold-start flag reports whether the last reset came from power-on or from a supply dip. Software reads it and clears it with a one-cycle strobe. Debug and watchdog resets leave the flag unchanged. The synchronous power-on input `por_i` puts the whole block into its initial state.

Top module: `rstsup_top`

## Requirements
- R1: When `lv_below_i` is held at 1, `mcu_rst_o` rises exactly SYNC_STAGES+FILT_CYC+1 rising edges after the first edge that samples it high (default 2+4+1 = 7).
- R2: A high pulse on `lv_below_i` that spans fewer than FILT_CYC sampling edges never raises `mcu_rst_o` and never sets `cold_flag_o`.
- R3: Once no source is active, `mcu_rst_o` drops on the (STRETCH_CYC+1)-th rising edge that sees no active source. The count starts at the first such edge. For debug, watchdog or `por_i` release this is STRETCH_CYC+1 edges after the source is removed. For the supply input it is SYNC_STAGES+STRETCH_CYC+2 edges after `lv_below_i` returns to 0.
- R4: Supply-low detection raises the reset in every combination of `idle_i` and `pdown_i`. It has no disable.
- R5: A 1 on `dbg_rst_i` sets `mcu_rst_o` at the next edge, in any mode.
- R6: A 1 on `wdt_rst_i` sets `mcu_rst_o` at the next edge only while `idle_i` and `pdown_i` are both 0. In either low-power mode it is ignored and the reset stays low.
- R7: `cold_flag_o` reads 1 while `por_i` is applied and afterwards. It is also set one edge after an accepted supply-low event.
- R8: `cold_flag_o` goes to 0 only one edge after `cold_clr_i` = 1. Debug and watchdog resets leave its value unchanged.
- R9: If an accepted supply-low event and `cold_clr_i` occur in the same cycle, the flag is set (set wins).
- R10: `mcu_rst_o` is 1 while `por_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on initialisation, active high |
| lv_below_i | input | 1 | Raw comparator level, 1 = supply below threshold (asynchronous) |
| dbg_rst_i | input | 1 | Debug-port reset request |
| wdt_rst_i | input | 1 | Watchdog reset request |
| idle_i | input | 1 | Processor in idle mode |
| pdown_i | input | 1 | Processor in power-down mode |
| cold_clr_i | input | 1 | Software strobe that clears the cold-start flag |
| mcu_rst_o | output | 1 | Combined stretched reset, active high |
| cold_flag_o | output | 1 | Cold-start cause flag |

## Verification
Three kinds of internal fault show up at the ports, each within a bounded number of cycles:

- **Filter counter.** A corrupted count shifts the rise of `mcu_rst_o` away from the expected edge, or lets a short pulse through. Either is visible within FILT_CYC+SYNC_STAGES+1 edges of the stimulus.
- **Stretch counter.** A stuck or wrong count moves the falling edge of the reset away from its fixed distance after the last source. A stuck count can also hold the reset high without end.
- **Cause flag.** A wrong flag value persists until software clears it, so it can be read at the port on the cycle after the event that should have set it or left it alone.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef struct packed {
    logic lv;
    logic dbg;
    logic wdt;
  } rst_src_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rstsup_lv_filter.sv
module rstsup_lv_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lv_raw_i,
  output logic lv_acc_o
);
  import rstsup_pkg::*;

  localparam int unsigned CW = cnt_w(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          lv_s;
  logic [CW-1:0] cnt_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign lv_s = lv_raw_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= lv_raw_i;
          for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign lv_s = sh_q[SYNC_STAGES-1];
    end
  endgenerate

  // A supply-low level is accepted after FILT_CYC consecutive high samples.
  always_ff @(posedge clk_i) begin
    if (rst_i || !lv_s) begin
      cnt_q    <= '0;
      lv_acc_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      lv_acc_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rstsup_src_gate.sv
module rstsup_src_gate (
  input  logic                  lv_acc_i,
  input  logic                  dbg_i,
  input  logic                  wdt_i,
  input  logic                  idle_i,
  input  logic                  pdown_i,
  output rstsup_pkg::rst_src_t  src_o,
  output logic                  any_o
);
  // Supply-low and debug requests pass in all modes; the watchdog is gated.
  always_comb begin
    src_o.lv  = lv_acc_i;
    src_o.dbg = dbg_i;
    src_o.wdt = wdt_i & ~idle_i & ~pdown_i;
    any_o     = src_o.lv | src_o.dbg | src_o.wdt;
  end

endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int unsigned STRETCH_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic rst_o
);
  import rstsup_pkg::*;

  localparam int unsigned SW = cnt_w(STRETCH_CYC);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYC);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || req_i) begin
      cnt_q <= LOAD;
      rst_o <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      rst_o <= 1'b1;
    end else begin
      rst_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rstsup_cause.sv
module rstsup_cause (
  input  logic clk_i,
  input  logic por_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // Set has priority over the software clear.
  always_ff @(posedge clk_i) begin
    if (por_i || set_i) flag_o <= 1'b1;
    else if (clr_i)     flag_o <= 1'b0;
  end

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned STRETCH_CYC = 8
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic lv_below_i,
  input  logic dbg_rst_i,
  input  logic wdt_rst_i,
  input  logic idle_i,
  input  logic pdown_i,
  input  logic cold_clr_i,
  output logic mcu_rst_o,
  output logic cold_flag_o
);
  import rstsup_pkg::*;

  logic     lv_acc;
  rst_src_t src;
  logic     src_any;

  rstsup_lv_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
    .clk_i    (clk_i),
    .rst_i    (por_i),
    .lv_raw_i (lv_below_i),
    .lv_acc_o (lv_acc)
  );

  rstsup_src_gate u_gate (
    .lv_acc_i (lv_acc),
    .dbg_i    (dbg_rst_i),
    .wdt_i    (wdt_rst_i),
    .idle_i   (idle_i),
    .pdown_i  (pdown_i),
    .src_o    (src),
    .any_o    (src_any)
  );

  rstsup_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
    .clk_i (clk_i),
    .rst_i (por_i),
    .req_i (src_any),
    .rst_o (mcu_rst_o)
  );

  rstsup_cause u_cause (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .set_i  (src.lv),
    .clr_i  (cold_clr_i),
    .flag_o (cold_flag_o)
  );

endmodule

// File: rtl/rstsup_checks.sv
module rstsup_checks #(
  parameter int unsigned STRETCH_CYC = 8
) (
  input logic clk_i,
  input logic por_i,
  input logic lv_acc,
  input logic dbg_rst_i,
  input logic wdt_rst_i,
  input logic idle_i,
  input logic pdown_i,
  input logic cold_clr_i,
  input logic mcu_rst_o,
  input logic cold_flag_o
);
  localparam int unsigned LIM = STRETCH_CYC + 1;
  localparam int unsigned QW  = $clog2(LIM + 1);

  logic          wdt_live;
  logic          busy;
  logic [QW-1:0] quiet_q;

  assign wdt_live = wdt_rst_i && !idle_i && !pdown_i;
  assign busy     = lv_acc || dbg_rst_i || wdt_live;

  always_ff @(posedge clk_i) begin
    if (por_i || busy)             quiet_q <= '0;
    else if (quiet_q != QW'(LIM)) quiet_q <= quiet_q + 1'b1;
  end

  a_r10_por_holds: assert property (@(posedge clk_i) por_i |=> mcu_rst_o);
  a_r4_lv_any_mode: assert property (@(posedge clk_i) disable iff (por_i) lv_acc |=> mcu_rst_o);
  a_r5_dbg_any_mode: assert property (@(posedge clk_i) disable iff (por_i) dbg_rst_i |=> mcu_rst_o);
  a_r6_wdt_live: assert property (@(posedge clk_i) disable iff (por_i) wdt_live |=> mcu_rst_o);
  a_r6_wdt_masked: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_rst_i && (idle_i || pdown_i) && !dbg_rst_i && !lv_acc && !mcu_rst_o) |=> !mcu_rst_o);
  a_r3_stretch_len: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(mcu_rst_o) |-> (quiet_q == QW'(LIM)));
  a_r7_lv_sets: assert property (@(posedge clk_i) disable iff (por_i) lv_acc |=> cold_flag_o);
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (por_i)
    (cold_flag_o && !cold_clr_i) |=> cold_flag_o);
  a_r8_clr_works: assert property (@(posedge clk_i) disable iff (por_i)
    (cold_clr_i && !lv_acc) |=> !cold_flag_o);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (por_i)
    (cold_clr_i && lv_acc) |=> cold_flag_o);
  a_r8_no_spurious_set: assert property (@(posedge clk_i) disable iff (por_i)
    (!cold_flag_o && !lv_acc) |=> !cold_flag_o);

endmodule

bind rstsup_top rstsup_checks #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .lv_acc      (lv_acc),
  .dbg_rst_i   (dbg_rst_i),
  .wdt_rst_i   (wdt_rst_i),
  .idle_i      (idle_i),
  .pdown_i     (pdown_i),
  .cold_clr_i  (cold_clr_i),
  .mcu_rst_o   (mcu_rst_o),
  .cold_flag_o (cold_flag_o)
);

// File: tb/rstsup_top_bench.sv
module rstsup_top_bench;
  localparam int unsigned SYNC = 2;
  localparam int unsigned FILT = 4;
  localparam int unsigned STR  = 8;
  localparam int NVEC = 8;
  // {pulse length[7:3], idle[2], pdown[1], expect reset[0]}
  localparam logic [7:0] VEC [0:NVEC-1] = '{
    {5'd1, 1'b0, 1'b0, 1'b0},
    {5'd3, 1'b0, 1'b0, 1'b0},
    {5'd4, 1'b0, 1'b0, 1'b1},
    {5'd5, 1'b1, 1'b0, 1'b1},
    {5'd3, 1'b1, 1'b0, 1'b0},
    {5'd4, 1'b0, 1'b1, 1'b1},
    {5'd2, 1'b0, 1'b1, 1'b0},
    {5'd9, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic por = 1'b1, lv = 1'b0, dbg = 1'b0, wdt = 1'b0;
  logic idle = 1'b0, pdown = 1'b0, clr = 1'b0;
  logic mcu_rst, cold;
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  rstsup_top #(.SYNC_STAGES(SYNC), .FILT_CYC(FILT), .STRETCH_CYC(STR)) u_rstsup_top (
    .clk_i(clk), .por_i(por), .lv_below_i(lv), .dbg_rst_i(dbg), .wdt_rst_i(wdt),
    .idle_i(idle), .pdown_i(pdown), .cold_clr_i(clr),
    .mcu_rst_o(mcu_rst), .cold_flag_o(cold)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count rising edges until mcu_rst reaches val (sampled at the falling edge).
  task automatic edges_until(input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mcu_rst !== val && n < 200);
  endtask

  task automatic strobe_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit saw;
    // R10 / R7: power-on state
    repeat (3) @(negedge clk);
    check("R10 reset during por", mcu_rst, 1);
    check("R7 flag after por", cold, 1);
    por = 1'b0;
    edges_until(1'b0, n);
    check("R3 stretch after por", n, STR + 1);
    check("R7 flag kept after por", cold, 1);
    strobe_clear();
    check("R8 software clear", cold, 0);

    // Table of supply-input pulses (R1, R2, R4, R7)
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      idle = VEC[v][2]; pdown = VEC[v][1];
      lv = 1'b1;
      repeat (int'(VEC[v][7:3])) @(negedge clk);
      lv = 1'b0;
      saw = mcu_rst;
      repeat (SYNC + FILT + STR + 8) begin
        @(negedge clk);
        if (mcu_rst) saw = 1'b1;
      end
      check(VEC[v][0] ? "R4 lv reset in mode" : "R2 short pulse rejected", saw, VEC[v][0]);
      check(VEC[v][0] ? "R7 flag set by lv" : "R2 flag untouched", cold, VEC[v][0]);
      strobe_clear();
      idle = 1'b0; pdown = 1'b0;
    end

    // R1 rise latency and R3 release latency on the supply input
    @(negedge clk) lv = 1'b1;
    edges_until(1'b1, n);
    check("R1 rise latency", n, SYNC + FILT + 1);
    repeat (3) @(negedge clk);
    lv = 1'b0;
    edges_until(1'b0, n);
    check("R3 release after lv", n, SYNC + STR + 2);
    check("R7 flag after lv", cold, 1);

    // R9: clear held while an event is accepted
    @(negedge clk) begin clr = 1'b1; lv = 1'b1; end
    repeat (SYNC + FILT + 3) @(negedge clk);
    check("R9 set beats clear", cold, 1);
    lv = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    clr = 1'b0;
    check("R8 clear after event", cold, 0);
    edges_until(1'b0, n);

    // R5: debug reset in power-down
    @(negedge clk) begin pdown = 1'b1; dbg = 1'b1; end
    @(negedge clk);
    check("R5 debug in power-down", mcu_rst, 1);
    dbg = 1'b0;
    edges_until(1'b0, n);
    check("R3 stretch after debug", n, STR + 1);
    check("R8 debug keeps flag", cold, 0);

    // R6: watchdog masked in idle and power-down
    saw = 1'b0;
    @(negedge clk) begin pdown = 1'b0; idle = 1'b1; wdt = 1'b1; end
    repeat (5) begin @(negedge clk); if (mcu_rst) saw = 1'b1; end
    idle = 1'b0; pdown = 1'b1;
    repeat (5) begin @(negedge clk); if (mcu_rst) saw = 1'b1; end
    check("R6 watchdog ignored in low power", saw, 0);
    pdown = 1'b0;
    @(negedge clk);
    check("R6 watchdog active in run", mcu_rst, 1);
    wdt = 1'b0;
    edges_until(1'b0, n);
    check("R3 stretch after watchdog", n, STR + 1);
    check("R8 watchdog keeps flag", cold, 0);

    // R8: a set flag survives debug reset
    @(negedge clk) lv = 1'b1;
    repeat (SYNC + FILT + 2) @(negedge clk);
    lv = 1'b0;
    edges_until(1'b0, n);
    @(negedge clk) dbg = 1'b1;
    @(negedge clk) dbg = 1'b0;
    edges_until(1'b0, n);
    check("R8 debug leaves set flag", cold, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule